// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block stands between software and the sequencer of an embedded flash array and decides whether the array may be touched. Software writes a key value and a download-enable bit through a small register port. A request to fetch the program/erase routines into working memory is granted only when that bit is set and the key holds the download code. A request to start a program or erase operation is accepted only when the key holds a second, different code.

While an operation runs, the block watches for four kinds of misbehaviour:

- an interrupt arriving,
- any read of the array,
- entry into a sleep or standby state,
- the bus being granted to a master other than the processor.

Any one of them aborts the operation. The block then raises a one-cycle abort strobe toward the sequencer and sets a sticky error flag. While that flag is set, no further program or erase can start and the key cannot be rewritten. Only reset clears the flag.

Top module: `flash_guard`

## Requirements
- R1: After reset the key reads 8'h00, the download-enable bit reads 0, and dlGrant, peStart, opActive, errFlag and abortPulse are all 0.
- R2: Register address 0 is the key and reads back what was last written. At address 1, a write sets the download-enable bit from data bit 0. A read of address 1 returns the error flag in bit 7, the operation-active flag in bit 6, the download-enable bit in bit 0, and zero in all other bits.
- R3: dlGrant pulses for one cycle, in the cycle after dlReq is sampled, if and only if the download-enable bit is 1, the key equals 8'hA5, and no operation is active.
- R4: When peReq is sampled, opActive rises in the next cycle and peStart pulses in that same cycle if and only if all three hold: the key equals 8'h5A, the error flag is 0, and no operation is active. Any other key value, including 8'hA5 and 8'h00, starts nothing.
- R5: If irqIn, arrayRd, sleepReq or altGrant is sampled high while opActive is 1, then in the next cycle:
  - opActive is 0,
  - errFlag is 1,
  - abortPulse is 1 for exactly that one cycle.
- R6: A violation input sampled while no operation is active changes neither errFlag nor abortPulse.
- R7: Once errFlag is set it stays set until reset, and every later peReq is refused.
- R8: A key write made while errFlag is set leaves the key unchanged.
- R9: If peDone is sampled while opActive is 1, opActive falls in the next cycle with no abort. If a violation is sampled in the same cycle as peDone, the abort behaviour of R5 applies instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register address: 0 selects the key, 1 selects control/status |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr |
| dlReq | input | 1 | Request to download the program/erase routines |
| peReq | input | 1 | Request to start a program or erase operation |
| peDone | input | 1 | Sequencer signals that the operation completed normally |
| irqIn | input | 1 | Interrupt (including non-maskable) taken |
| arrayRd | input | 1 | Flash array read, including a vector read or an instruction fetch |
| sleepReq | input | 1 | Entry into sleep or software standby |
| altGrant | input | 1 | Bus granted to a master other than the processor |
| dlGrant | output | 1 | One-cycle download permission |
| peStart | output | 1 | One-cycle start strobe toward the sequencer |
| opActive | output | 1 | A program/erase operation is running |
| errFlag | output | 1 | Sticky error-protected state |
| abortPulse | output | 1 | One-cycle abort strobe toward the sequencer |

## Verification
The hardest state to reach is error protection combined with an attempt to unlock. Reaching it requires three things in order: a correctly keyed start, then a violation during the operation, then a key rewrite with a fresh request. The bench builds this sequence for each of the four violation sources. After each one it reads the key back and retries the start, so that a leaking lock shows at the ports. It also sweeps all 256 key values against both requests, and issues each violation while idle, so that false triggers are covered as well as true ones.

// File: rtl/fg_pkg.sv
package fg_pkg;
  // Strobes driven by the control path toward the register datapath.
  typedef struct packed {
    logic keyLock;    // freeze the key register
    logic statusErr;  // status bit: error flag
    logic statusBusy; // status bit: operation active
  } fgStrobe_t;
endpackage

// File: rtl/fg_regs.sv
module fg_regs
  import fg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 1,
  parameter logic [DATA_W-1:0] DL_KEY = 8'hA5,
  parameter logic [DATA_W-1:0] PE_KEY = 8'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  fgStrobe_t         strobe,
  output logic              dlKeyOk,
  output logic              peKeyOk,
  output logic              dlEnable
);
  localparam logic [ADDR_W-1:0] KEY_ADDR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(1);
  localparam int ERR_BIT  = DATA_W - 1;
  localparam int BUSY_BIT = DATA_W - 2;

  logic [DATA_W-1:0] keyReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyReg   <= '0;
      dlEnable <= 1'b0;
    end else if (regWrEn) begin
      if (regAddr == KEY_ADDR && !strobe.keyLock) keyReg <= regWrData;
      if (regAddr == CTRL_ADDR) dlEnable <= regWrData[0];
    end
  end

  assign dlKeyOk = (keyReg == DL_KEY);
  assign peKeyOk = (keyReg == PE_KEY);

  always_comb begin
    regRdData = '0;
    if (regAddr == KEY_ADDR) begin
      regRdData = keyReg;
    end else if (regAddr == CTRL_ADDR) begin
      regRdData[0]        = dlEnable;
      regRdData[ERR_BIT]  = strobe.statusErr;
      regRdData[BUSY_BIT] = strobe.statusBusy;
    end
  end

  AST_KEY_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.keyLock |=> $stable(keyReg)); // R8
  AST_KEY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(dlKeyOk && peKeyOk)); // R4
endmodule

// File: rtl/fg_ctrl.sv
module fg_ctrl
  import fg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      dlReq,
  input  logic      peReq,
  input  logic      peDone,
  input  logic      irqIn,
  input  logic      arrayRd,
  input  logic      sleepReq,
  input  logic      altGrant,
  input  logic      dlKeyOk,
  input  logic      peKeyOk,
  input  logic      dlEnable,
  output logic      dlGrant,
  output logic      peStart,
  output logic      opActive,
  output logic      errFlag,
  output logic      abortPulse,
  output fgStrobe_t strobe
);
  logic anyViol, violHit, startOk;

  assign anyViol = irqIn | arrayRd | sleepReq | altGrant;
  assign violHit = opActive & anyViol;
  assign startOk = peReq & peKeyOk & ~errFlag & ~opActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlGrant    <= 1'b0;
      peStart    <= 1'b0;
      opActive   <= 1'b0;
      errFlag    <= 1'b0;
      abortPulse <= 1'b0;
    end else begin
      dlGrant    <= dlReq & dlEnable & dlKeyOk & ~opActive;
      peStart    <= startOk;
      abortPulse <= violHit;
      if (violHit) begin
        opActive <= 1'b0;
        errFlag  <= 1'b1;
      end else if (opActive && peDone) begin
        opActive <= 1'b0;
      end else if (startOk) begin
        opActive <= 1'b1;
      end
    end
  end

  assign strobe.keyLock    = errFlag;
  assign strobe.statusErr  = errFlag;
  assign strobe.statusBusy = opActive;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R7
  AST_NO_START_IN_ERR: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> !peStart); // R7
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse); // R5
  AST_ABORT_STATE: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> (errFlag && !opActive)); // R5
  AST_VIOL_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    (opActive && anyViol) |=> (abortPulse && !opActive)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!opActive && !errFlag) |=> (!errFlag && !abortPulse)); // R6
  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    peStart |-> $rose(opActive)); // R4
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 1,
  parameter logic [DATA_W-1:0] DL_KEY = 8'hA5,
  parameter logic [DATA_W-1:0] PE_KEY = 8'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              dlReq,
  input  logic              peReq,
  input  logic              peDone,
  input  logic              irqIn,
  input  logic              arrayRd,
  input  logic              sleepReq,
  input  logic              altGrant,
  output logic              dlGrant,
  output logic              peStart,
  output logic              opActive,
  output logic              errFlag,
  output logic              abortPulse
);
  fgStrobe_t strobe;
  logic dlKeyOk, peKeyOk, dlEnable;

  fg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DL_KEY(DL_KEY), .PE_KEY(PE_KEY)) u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .dlKeyOk(dlKeyOk), .peKeyOk(peKeyOk), .dlEnable(dlEnable)
  );

  fg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dlReq(dlReq), .peReq(peReq), .peDone(peDone),
    .irqIn(irqIn), .arrayRd(arrayRd), .sleepReq(sleepReq), .altGrant(altGrant),
    .dlKeyOk(dlKeyOk), .peKeyOk(peKeyOk), .dlEnable(dlEnable),
    .dlGrant(dlGrant), .peStart(peStart), .opActive(opActive),
    .errFlag(errFlag), .abortPulse(abortPulse), .strobe(strobe)
  );
endmodule

// File: tb/flash_guard_bench.sv
module flash_guard_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [0:0] regAddr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic dlReq = 1'b0, peReq = 1'b0, peDone = 1'b0;
  logic irqIn = 1'b0, arrayRd = 1'b0, sleepReq = 1'b0, altGrant = 1'b0;
  logic dlGrant, peStart, opActive, errFlag, abortPulse;

  int checks = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flash_guard u_flash_guard (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .dlReq(dlReq), .peReq(peReq),
    .peDone(peDone), .irqIn(irqIn), .arrayRd(arrayRd), .sleepReq(sleepReq),
    .altGrant(altGrant), .dlGrant(dlGrant), .peStart(peStart), .opActive(opActive),
    .errFlag(errFlag), .abortPulse(abortPulse)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic wr(logic a, logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic setViol(int k, logic v);
    case (k)
      0: irqIn = v;
      1: arrayRd = v;
      2: sleepReq = v;
      default: altGrant = v;
    endcase
  endtask

  initial begin
    logic [7:0] r;
    doReset();

    // R1: reset state
    rd(1'b0, r); expect8("R1 key", r, 8'h00);
    rd(1'b1, r); expect8("R1 ctrl", r, 8'h00);
    expect8("R1 outs", {3'b0, dlGrant, peStart, opActive, errFlag, abortPulse}, 8'h00);

    // R2: register map
    wr(1'b0, 8'h3C); rd(1'b0, r); expect8("R2 key rb", r, 8'h3C);
    wr(1'b1, 8'hFF); rd(1'b1, r); expect8("R2 ctrl rb", r, 8'h01);
    wr(1'b1, 8'h00); rd(1'b1, r); expect8("R2 ctrl clr", r, 8'h00);

    // R3: download sweep over every key and both enable values
    for (int en = 0; en < 2; en++) begin
      wr(1'b1, 8'(en));
      for (int k = 0; k < 256; k++) begin
        wr(1'b0, 8'(k));
        dlReq = 1'b1;
        tick();
        dlReq = 1'b0;
        expect8("R3 dlGrant", {7'b0, dlGrant}, {7'b0, (en == 1 && k == 8'hA5)});
        tick();
        expect8("R3 dlGrant pulse", {7'b0, dlGrant}, 8'h00);
      end
    end

    // R4 / R9: program-erase key sweep with normal completion
    for (int k = 0; k < 256; k++) begin
      logic exp;
      exp = (k == 8'h5A);
      wr(1'b0, 8'(k));
      peReq = 1'b1;
      tick();
      peReq = 1'b0;
      expect8("R4 start", {6'b0, peStart, opActive}, {6'b0, exp, exp});
      peDone = 1'b1;
      tick();
      peDone = 1'b0;
      expect8("R9 done", {5'b0, opActive, abortPulse, errFlag}, 8'h00);
    end

    // R3: download refused while an operation is active
    wr(1'b1, 8'h01); wr(1'b0, 8'h5A);
    peReq = 1'b1; tick(); peReq = 1'b0;
    wr(1'b0, 8'hA5);
    dlReq = 1'b1; tick(); dlReq = 1'b0;
    expect8("R3 busy dl", {7'b0, dlGrant}, 8'h00);
    rd(1'b1, r); expect8("R2 busy status", r, 8'h41);
    peDone = 1'b1; tick(); peDone = 1'b0;

    // R5 R6 R7 R8: each violation source, idle and during an operation
    for (int v = 0; v < 4; v++) begin
      doReset();
      setViol(v, 1'b1); tick(); setViol(v, 1'b0);
      expect8("R6 idle viol", {6'b0, errFlag, abortPulse}, 8'h00);

      wr(1'b0, 8'h5A);
      peReq = 1'b1; tick(); peReq = 1'b0;
      expect8("R4 started", {7'b0, opActive}, 8'h01);
      setViol(v, 1'b1); tick(); setViol(v, 1'b0);
      expect8("R5 abort", {5'b0, opActive, errFlag, abortPulse}, 8'h03);
      tick();
      expect8("R5 abort pulse", {7'b0, abortPulse}, 8'h00);
      rd(1'b1, r); expect8("R2 err status", r, 8'h80);

      wr(1'b0, 8'h11);
      rd(1'b0, r); expect8("R8 key locked", r, 8'h5A);
      peReq = 1'b1; tick(); peReq = 1'b0;
      expect8("R7 refused", {6'b0, peStart, opActive}, 8'h00);
      repeat (3) tick();
      expect8("R7 sticky", {7'b0, errFlag}, 8'h01);
    end

    // R9: violation together with done takes the abort path
    doReset();
    wr(1'b0, 8'h5A);
    peReq = 1'b1; tick(); peReq = 1'b0;
    peDone = 1'b1; arrayRd = 1'b1; tick(); peDone = 1'b0; arrayRd = 1'b0;
    expect8("R9 viol beats done", {5'b0, opActive, errFlag, abortPulse}, 8'h03);

    // R1: reset clears the error state
    doReset();
    expect8("R1 err cleared", {7'b0, errFlag}, 8'h00);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule